// File: doc/BRIEF.md
# Sequence-Armed Watchdog and Power-Down Controller

This block sits beside an instruction sequencer and turns a handful of decoded instruction strobes into watchdog and power-down control. A free-running down-counter sets a timeout flag when it expires. A watchdog-restart instruction asks the sequencer to skip the next instruction when that flag is set, clears the flag, and restarts the count.

Two actions need a pair of instructions in strict succession. Disabling the watchdog needs the restart instruction to come directly after a disable-arm instruction. Power-down entry needs the power-off instruction to come directly after a power-off-arm instruction. Any other retired instruction in between drops the arming. Cycles in which no instruction retires leave the arming unchanged.

Each strobe is qualified by `instr_ret`. A cycle with `instr_ret` high and no strobe set counts as one retired other instruction. At most one strobe is high at a time.

Top module: `wdt_pwr_ctrl`

## Requirements
- R1: While the watchdog is enabled, `wdf` rises exactly PERIOD clock edges after reset or after the last restart, and the count then starts again.
- R2: `skip` is high in the same cycle as a retired restart (`instr_ret` and `op_wrst` both high) when `wdf` is 1, and is low otherwise.
- R3: A retired restart clears `wdf` and reloads the counter. The change shows after the next clock edge.
- R4: A restart retired as the next instruction after a disable-arm (`op_dwdt`) drops `wdt_en` from the next cycle on. `wdt_en` never rises again before reset.
- R5: While `wdt_en` is 0 the counter holds its value and `wdf` is never set.
- R6: Any other retired instruction between an arming instruction and its target cancels the arming, so the target then has no sequence effect.
- R7: Cycles with `instr_ret` low neither cancel nor create an arming.
- R8: A power-off (`op_pof`) retired as the next instruction after a power-off-arm (`op_epof`) drives `pd_req` high for exactly the one cycle after its clock edge.
- R9: A power-off that does not directly follow a power-off-arm leaves `pd_req` low.
- R10: After reset, `wdt_en` is 1, `wdf` is 0, `pd_req` is 0 and nothing is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_ret | input | 1 | An instruction retires this cycle |
| op_wrst | input | 1 | Retiring instruction is watchdog restart |
| op_dwdt | input | 1 | Retiring instruction is watchdog disable-arm |
| op_epof | input | 1 | Retiring instruction is power-off-arm |
| op_pof | input | 1 | Retiring instruction is power-off |
| skip | output | 1 | Skip the next instruction |
| wdf | output | 1 | Watchdog timeout flag |
| wdt_en | output | 1 | Watchdog enabled |
| pd_req | output | 1 | Power-down request pulse |

## Verification
`skip` is combinational, so it is sampled in the same cycle as the retiring restart, after the inputs settle and before the clock edge. `wdf`, `wdt_en` and `pd_req` each pass through one register, so they are sampled one time unit after the edge that takes in the instruction. The timeout is checked by counting edges after a restart: the flag must be low after PERIOD-1 edges and high after the PERIOD-th. The `pd_req` pulse is checked on two consecutive post-edge samples, high and then low.

// File: rtl/wdt_pwr_ctrl.sv
module wdt_pwr_ctrl #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_ret,
  input  logic op_wrst,
  input  logic op_dwdt,
  input  logic op_epof,
  input  logic op_pof,
  output logic skip,
  output logic wdf,
  output logic wdt_en,
  output logic pd_req
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;
  logic arm_dis, arm_pd;

  wire wrst_go = instr_ret & op_wrst;
  wire pof_go  = instr_ret & op_pof;

  assign skip = wrst_go & wdf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= RELOAD;
      wdf     <= 1'b0;
      wdt_en  <= 1'b1;
      arm_dis <= 1'b0;
      arm_pd  <= 1'b0;
      pd_req  <= 1'b0;
    end else begin
      pd_req <= pof_go & arm_pd;
      if (instr_ret) begin
        arm_dis <= op_dwdt;
        arm_pd  <= op_epof;
      end
      if (wrst_go && arm_dis) wdt_en <= 1'b0;
      if (wrst_go) begin
        cnt <= RELOAD;
        wdf <= 1'b0;
      end else if (wdt_en) begin
        if (cnt == '0) begin
          wdf <= 1'b1;
          cnt <= RELOAD;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ret |-> $onehot0({op_wrst, op_dwdt, op_epof, op_pof}));

  a_r1_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_en && cnt == '0 && !wrst_go) |=> wdf);

  a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wrst_go |=> (!wdf && cnt == RELOAD));

  a_r4_enable_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> !wdt_en);

  a_r5_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_en && !wrst_go) |=> ($stable(cnt) && $stable(wdf)));

  a_r7_idle_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_ret |=> ($stable(arm_dis) && $stable(arm_pd)));

  a_r8_pd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> !pd_req);

  a_r9_pd_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (pof_go && !arm_pd) |=> !pd_req);
endmodule

// File: tb/sim_wdt_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_wdt_pwr_ctrl;
  localparam int P = 24;
  localparam int K_OTHER = 0, K_WRST = 1, K_DWDT = 2, K_EPOF = 3, K_POF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_ret = 1'b0, op_wrst = 1'b0, op_dwdt = 1'b0, op_epof = 1'b0, op_pof = 1'b0;
  logic skip, wdf, wdt_en, pd_req;
  logic last_skip;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_pwr_ctrl #(.PERIOD(P)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_ret(instr_ret),
    .op_wrst(op_wrst), .op_dwdt(op_dwdt), .op_epof(op_epof), .op_pof(op_pof),
    .skip(skip), .wdf(wdf), .wdt_en(wdt_en), .pd_req(pd_req)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Retire one instruction; skip captured before the edge, outputs settled after it.
  task automatic issue(input int kind);
    @(negedge clk);
    instr_ret = 1'b1;
    op_wrst = (kind == K_WRST);
    op_dwdt = (kind == K_DWDT);
    op_epof = (kind == K_EPOF);
    op_pof  = (kind == K_POF);
    #1 last_skip = skip;
    @(posedge clk);
    #1;
    instr_ret = 1'b0;
    {op_wrst, op_dwdt, op_epof, op_pof} = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    #1;
    check("R10 wdt_en", wdt_en, 1'b1);
    check("R10 wdf", wdf, 1'b0);
    check("R10 pd_req", pd_req, 1'b0);
    check("R10 skip", skip, 1'b0);
  endtask

  task automatic t_expiry;
    issue(K_WRST);
    check("R2 no skip when flag low", last_skip, 1'b0);
    idle(P - 1);
    check("R1 flag low before period", wdf, 1'b0);
    idle(1);
    check("R1 flag high at period", wdf, 1'b1);
  endtask

  task automatic t_skip;
    issue(K_WRST);
    check("R2 skip when flag high", last_skip, 1'b1);
    check("R3 flag cleared", wdf, 1'b0);
    check("R2 skip low after", skip, 1'b0);
  endtask

  task automatic t_powerdown;
    issue(K_EPOF);
    issue(K_POF);
    check("R8 pd_req pulse", pd_req, 1'b1);
    idle(1);
    check("R8 pd_req one cycle", pd_req, 1'b0);
    issue(K_POF);
    check("R9 lone pof", pd_req, 1'b0);
    issue(K_EPOF);
    issue(K_OTHER);
    issue(K_POF);
    check("R6 epof disarmed by other", pd_req, 1'b0);
    issue(K_EPOF);
    issue(K_WRST);
    issue(K_POF);
    check("R6 epof disarmed by wrst", pd_req, 1'b0);
    issue(K_EPOF);
    idle(3);
    issue(K_POF);
    check("R7 idle keeps epof arm", pd_req, 1'b1);
    idle(1);
  endtask

  task automatic t_disarm_dwdt;
    issue(K_DWDT);
    issue(K_OTHER);
    issue(K_WRST);
    check("R6 dwdt disarmed", wdt_en, 1'b1);
    issue(K_DWDT);
    issue(K_POF);
    issue(K_WRST);
    check("R6 dwdt disarmed by pof", wdt_en, 1'b1);
  endtask

  task automatic t_disable;
    issue(K_WRST);
    idle(P);
    check("R1 flag set again", wdf, 1'b1);
    issue(K_DWDT);
    idle(2);
    issue(K_WRST);
    check("R2 skip on disabling wrst", last_skip, 1'b1);
    check("R4 watchdog disabled", wdt_en, 1'b0);
    check("R3 flag cleared on disable", wdf, 1'b0);
    idle(3 * P);
    check("R5 no expiry while off", wdf, 1'b0);
    check("R4 stays disabled", wdt_en, 1'b0);
    issue(K_WRST);
    check("R4 wrst does not re-enable", wdt_en, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_expiry();
    t_skip();
    t_powerdown();
    t_disarm_dwdt();
    t_disable();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule